// File: doc/BRIEF.md
# Destination MAC Address Filter

This block decides, for every received Ethernet frame, whether its destination address is acceptable. A byte-wide receive stream enters with a valid strobe and a start-of-frame strobe. The block collects the first six bytes, which form the destination address, and looks them up in a small table of station addresses. It then reports one pass or fail verdict per frame. A downstream stage uses the verdict to keep or drop the frame.

Software fills the table through a 32-bit write port. Each entry occupies two word positions. A register selects one of four filtering policies:

- accept everything;
- accept only table hits;
- accept table hits and broadcast;
- accept table hits, broadcast and multicast.

While the receiver is running, the table is frozen. The policy register can be rewritten at any time.

Top module: `mac_dst_filter`

## Requirements
- R1: After reset `res_valid` and `res_pass` are 0, the filtering policy is 0 (accept all), and every table entry is invalid, so none matches any address, including address zero.
- R2: `res_valid` is high for exactly one cycle: the cycle after the sixth accepted byte of a frame. A byte is accepted when `in_valid` is 1. The byte accepted with `in_sof`=1 is the first. Idle cycles between bytes are allowed. Bytes after the sixth, and bytes arriving before any start of frame, give no verdict. A new start of frame restarts the count. `res_pass` is 0 whenever `res_valid` is 0.
- R3: With policy 0 every frame passes.
- R4: With policy 1 a frame passes only if its destination equals the address of a valid table entry. Destination byte 0 (first on the stream) maps to address bits 47:40, and byte 5 maps to bits 7:0.
- R5: Policy 2 also passes the broadcast destination, which is all 48 bits set.
- R6: Policy 3 also passes multicast destinations, meaning bit 0 of destination byte 0 (address bit 40) is 1.
- R7: Entry k has two word positions. Its low word is at byte offset 0x80+8k and carries address bits 31:0. Its high word is at 0x84+8k and carries address bits 47:32 in data bits 15:0 and the valid flag in data bit 16.
- R8: A high-word write changes entry k only if the most recent table write before it was the low word of the same entry k. Non-table writes in between are allowed. A high-word write always consumes the pending low word. Any other order leaves the entry as it was.
- R9: Table writes made while `rx_enable`=1 are ignored, for both halves.
- R10: The policy is data bits 1:0 of a write to byte offset 0x38. It is accepted regardless of `rx_enable`, and the other data bits are ignored.
- R11: An entry committed with valid flag 0 takes no part in matching, even when its address bits equal the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver running; freezes the table when 1 |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte offset of the write (word aligned) |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_data | input | 8 | Stream byte |
| res_valid | output | 1 | Verdict strobe, one per frame |
| res_pass | output | 1 | Frame accepted (meaningful with res_valid) |

## Verification
The properties assume the following inputs:
- a reset held for at least one cycle before traffic;
- `in_sof` raised only together with `in_valid`;
- known values on all inputs outside reset.

The policy properties compare a verdict against the policy and destination of the cycle before it. They therefore rely on the header collector and the decision register being exactly one stage apart.

The stimulus is driven only on falling edges. It always pairs start of frame with a valid byte and keeps configuration addresses word aligned. It still covers frame gaps, restarted headers and headers without a start.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;

    localparam int MAC_W       = 48;
    localparam int BYTE_W      = 8;
    localparam int REG_W       = 32;
    localparam int HDR_BYTES   = MAC_W / BYTE_W;
    localparam int ENTRY_W     = MAC_W + 1;
    localparam int VLD_BIT     = 16;
    localparam int WORD_STRIDE = 8;
    localparam int MCAST_BIT   = MAC_W - BYTE_W;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [1:0] {
        FLT_ALL       = 2'd0,
        FLT_TABLE     = 2'd1,
        FLT_TBL_BC    = 2'd2,
        FLT_TBL_BC_MC = 2'd3
    } flt_mode_e;

    typedef struct packed {
        logic vld;
        mac_t mac;
    } tbl_entry_t;

    function automatic logic is_bcast(mac_t a);
        return &a;
    endfunction

    function automatic logic is_mcast(mac_t a);
        return a[MCAST_BIT];
    endfunction

    function automatic logic flt_accept(flt_mode_e m, logic hit, mac_t a);
        logic ok;
        case (m)
            FLT_ALL:    ok = 1'b1;
            FLT_TABLE:  ok = hit;
            FLT_TBL_BC: ok = hit | is_bcast(a);
            default:    ok = hit | is_bcast(a) | is_mcast(a);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mac_filt_hdr.sv
module mac_filt_hdr
    import mac_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output mac_t              dst_mac,
    output logic              dst_done
);

    localparam int PW = $clog2(HDR_BYTES + 1);
    localparam logic [PW-1:0] IDLE = PW'(HDR_BYTES);
    localparam logic [PW-1:0] LAST = PW'(HDR_BYTES - 1);

    logic [PW-1:0]           pos_q;
    logic [PW-1:0]           at_pos;
    logic [MAC_W-BYTE_W-1:0] sh_q;
    logic                    take;

    always_comb begin
        at_pos   = in_sof ? '0 : pos_q;
        take     = in_valid && (at_pos < IDLE);
        dst_done = take && (at_pos == LAST);
        dst_mac  = {sh_q, in_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= IDLE;
            sh_q  <= '0;
        end else if (take) begin
            pos_q <= at_pos + 1'b1;
            sh_q  <= dst_mac[MAC_W-BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/mac_filt_table.sv
module mac_filt_table
    import mac_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 8,
    parameter int TABLE_BASE  = 'h80
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           lock,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [REG_W-1:0]               wr_data,
    input  mac_t                           lookup,
    output logic                           hit,
    output logic [NUM_ENTRIES*ENTRY_W-1:0] tbl_flat
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int SPAN  = NUM_ENTRIES * WORD_STRIDE;

    int               off;
    logic             in_rng;
    logic             wr_lo;
    logic             wr_hi;
    logic             commit;
    logic [IDX_W-1:0] idx;

    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic [REG_W-1:0] pend_lo_q;

    logic [NUM_ENTRIES-1:0] match;

    always_comb begin
        off    = int'(wr_addr) - TABLE_BASE;
        in_rng = (off >= 0) && (off < SPAN) && (wr_addr[1:0] == 2'b00);
        idx    = IDX_W'(off / WORD_STRIDE);
        wr_lo  = wr_en && !lock && in_rng && !off[2];
        wr_hi  = wr_en && !lock && in_rng && off[2];
        commit = wr_hi && pend_q && (pend_idx_q == idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            pend_lo_q  <= '0;
        end else if (wr_lo) begin
            pend_q     <= 1'b1;
            pend_idx_q <= idx;
            pend_lo_q  <= wr_data;
        end else if (wr_hi) begin
            pend_q     <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        tbl_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (commit && (idx == IDX_W'(i))) begin
                ent_q <= '{vld: wr_data[VLD_BIT],
                           mac: {wr_data[MAC_W-REG_W-1:0], pend_lo_q}};
            end
        end

        assign match[i] = ent_q.vld && (ent_q.mac == lookup);
        assign tbl_flat[i*ENTRY_W +: ENTRY_W] = ent_q;
    end

    assign hit = |match;

endmodule

// File: rtl/mac_filt_decide.sv
module mac_filt_decide
    import mac_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flt_mode_e mode,
    input  logic      done,
    input  logic      hit,
    input  mac_t      dst,
    output logic      res_valid,
    output logic      res_pass
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
        end else begin
            res_valid <= done;
            res_pass  <= done && flt_accept(mode, hit, dst);
        end
    end

endmodule

// File: rtl/mac_dst_filter.sv
module mac_dst_filter
    import mac_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 8,
    parameter int TABLE_BASE  = 'h80,
    parameter int MODE_OFS    = 'h38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              res_valid,
    output logic              res_pass
);

    flt_mode_e                      cur_mode;
    mac_t                           dst_mac;
    logic                           hdr_done;
    logic                           tbl_hit;
    logic [NUM_ENTRIES*ENTRY_W-1:0] tbl_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= FLT_ALL;
        end else if (cfg_wr_en && (cfg_addr == ADDR_W'(MODE_OFS))) begin
            cur_mode <= flt_mode_e'(cfg_wdata[1:0]);
        end
    end

    mac_filt_hdr u_hdr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .dst_mac  (dst_mac),
        .dst_done (hdr_done)
    );

    mac_filt_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W),
        .TABLE_BASE  (TABLE_BASE)
    ) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .lock     (rx_enable),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .lookup   (dst_mac),
        .hit      (tbl_hit),
        .tbl_flat (tbl_flat)
    );

    mac_filt_decide u_dec (
        .clk       (clk),
        .rst       (rst),
        .mode      (cur_mode),
        .done      (hdr_done),
        .hit       (tbl_hit),
        .dst       (dst_mac),
        .res_valid (res_valid),
        .res_pass  (res_pass)
    );

endmodule

// File: rtl/mac_dst_filter_chk.sv
module mac_dst_filter_chk #(
    parameter int TW = 784
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_enable,
    input logic          res_valid,
    input logic          res_pass,
    input logic [1:0]    mode,
    input logic [47:0]   dst,
    input logic          dst_done,
    input logic          hit,
    input logic [TW-1:0] tbl
);

    assert_pass_qualified_R2: assert property (@(posedge clk) disable iff (rst)
        res_pass |-> res_valid);

    assert_verdict_follows_header_R2: assert property (@(posedge clk) disable iff (rst)
        dst_done |=> res_valid);

    assert_no_stray_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(dst_done));

    assert_promisc_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(mode) == 2'd0)) |-> res_pass);

    assert_table_only_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(mode) == 2'd1) && !$past(hit)) |-> !res_pass);

    assert_bcast_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(mode) >= 2'd2) && $past(&dst)) |-> res_pass);

    assert_mcast_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(mode) == 2'd3) && $past(dst[40])) |-> res_pass);

    assert_table_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rx_enable) |-> $stable(tbl));

endmodule

bind mac_dst_filter mac_dst_filter_chk #(.TW(NUM_ENTRIES * 49)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_enable (rx_enable),
    .res_valid (res_valid),
    .res_pass  (res_pass),
    .mode      (cur_mode),
    .dst       (dst_mac),
    .dst_done  (hdr_done),
    .hit       (tbl_hit),
    .tbl       (tbl_flat)
);

// File: tb/test_mac_dst_filter.sv
`timescale 1ns/1ps
module test_mac_dst_filter;

    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        res_valid;
    logic        res_pass;

    always #2.5 clk = ~clk;

    mac_dst_filter i_mac_dst_filter (
        .clk(clk), .rst(rst), .rx_enable(rx_enable),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .res_valid(res_valid), .res_pass(res_pass)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit [47:0] m_mac [NE];
    bit        m_v   [NE];
    bit        p_v;
    int        p_idx;
    bit [31:0] p_lo;
    int        m_mode;
    int        m_pos;
    bit [47:0] m_dst;
    bit        e_valid;
    bit        e_pass;

    task automatic chk(bit act, bit exp, string req, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic bit m_decide(bit [47:0] a);
        bit found = 0;
        for (int k = 0; k < NE; k++)
            if (m_v[k] && m_mac[k] == a) found = 1;
        if (m_mode == 0) return 1;
        if (m_mode == 1) return found;
        if (m_mode == 2) return found || (a == 48'hFFFF_FFFF_FFFF);
        return found || (a == 48'hFFFF_FFFF_FFFF) || a[40];
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int k = 0; k < NE; k++) begin m_mac[k] = '0; m_v[k] = 0; end
            p_v = 0; p_idx = 0; p_lo = '0; m_mode = 0; m_pos = 6; m_dst = '0;
            e_valid = 0; e_pass = 0;
        end else begin
            int p;
            bit nv;
            bit np;
            int a;
            nv = 0; np = 0;
            if (in_valid) begin
                p = in_sof ? 0 : m_pos;
                if (p < 6) begin
                    m_dst = {m_dst[39:0], in_data};
                    if (p == 5) begin nv = 1; np = m_decide(m_dst); end
                    m_pos = p + 1;
                end
            end
            e_valid = nv; e_pass = np;
            if (cfg_wr_en) begin
                a = int'(cfg_addr);
                if (a == 'h38) m_mode = int'(cfg_wdata[1:0]);
                else if (!rx_enable && a >= 'h80 && a < 'h80 + 8*NE && (a % 4) == 0) begin
                    if (((a - 'h80) % 8) == 0) begin
                        p_v = 1; p_idx = (a - 'h80) / 8; p_lo = cfg_wdata;
                    end else begin
                        if (p_v && p_idx == (a - 'h80) / 8) begin
                            m_mac[p_idx] = {cfg_wdata[15:0], p_lo};
                            m_v[p_idx]   = cfg_wdata[16];
                        end
                        p_v = 0;
                    end
                end
            end
        end
        @(negedge clk);
        chk(res_valid, e_valid, cur_req, "res_valid vs model");
        chk(res_pass, e_pass, cur_req, "res_pass vs model");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic cfg_write(int addr, bit [31:0] data);
        cfg_wr_en = 1; cfg_addr = 8'(addr); cfg_wdata = data;
        step();
        cfg_wr_en = 0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic wr_entry(int k, bit [47:0] mac, bit v);
        cfg_write('h80 + 8*k, mac[31:0]);
        cfg_write('h84 + 8*k, {15'd0, v, mac[47:32]});
    endtask

    task automatic send_frame(bit [47:0] mac, int gap, bit exp, string req, bit use_sof = 1);
        for (int b = 0; b < 6; b++) begin
            in_valid = 1; in_sof = use_sof && (b == 0); in_data = mac[47 - 8*b -: 8];
            step();
            in_valid = 0; in_sof = 0; in_data = '0;
            if (b == 5) begin
                chk(res_valid, use_sof, req, "verdict strobe after sixth byte");
                chk(res_pass, use_sof && exp, req, "verdict value");
            end else begin
                chk(res_valid, 0, req, "no verdict before sixth byte");
            end
            if (b < 5) idle(gap);
        end
        for (int b = 0; b < 2; b++) begin
            in_valid = 1; in_data = 8'hA5;
            step();
            chk(res_valid, 0, req, "no verdict for payload byte");
        end
        in_valid = 0; in_data = '0;
        idle(1);
    endtask

    task automatic partial(bit [47:0] mac, int n);
        for (int b = 0; b < n; b++) begin
            in_valid = 1; in_sof = (b == 0); in_data = mac[47 - 8*b -: 8];
            step();
            chk(res_valid, 0, "R2", "no verdict for short header");
        end
        in_valid = 0; in_sof = 0; in_data = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    localparam bit [47:0] A3  = 48'h02_11_22_33_44_55;
    localparam bit [47:0] A3X = 48'h02_11_22_33_44_56;
    localparam bit [47:0] A15 = 48'h0A_0B_0C_0D_0E_0F;
    localparam bit [47:0] A5  = 48'h02_00_00_00_05_05;
    localparam bit [47:0] A7  = 48'h02_00_00_00_07_07;
    localparam bit [47:0] A8  = 48'h02_00_00_00_08_08;
    localparam bit [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam bit [47:0] MC  = 48'h01_00_5E_00_00_01;
    localparam bit [47:0] UC  = 48'h02_99_99_99_99_99;

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst = 1;
        idle(3);
        chk(res_valid, 0, "R1", "res_valid in reset");
        chk(res_pass, 0, "R1", "res_pass in reset");
        rst = 0;
        idle(2);
        send_frame(48'h0, 0, 1, "R1");            // reset policy accepts all
        cur_req = "R3";
        send_frame(UC, 1, 1, "R3");
        cur_req = "R1";
        cfg_write('h38, 32'd1);
        send_frame(48'h0, 0, 0, "R1");            // zeroed entries do not match

        // R7 / R4: table contents and table-only policy
        cur_req = "R7";
        wr_entry(3, A3, 1);
        wr_entry(15, A15, 1);
        send_frame(A3, 0, 1, "R7");
        send_frame(A15, 0, 1, "R7");
        cur_req = "R4";
        send_frame(A3X, 0, 0, "R4");
        send_frame(BC, 0, 0, "R4");
        send_frame(MC, 0, 0, "R4");

        // R5 / R6 / R10
        cur_req = "R5";
        cfg_write('h38, 32'd2);
        send_frame(BC, 0, 1, "R5");
        send_frame(MC, 0, 0, "R5");
        send_frame(A3, 0, 1, "R5");
        cur_req = "R6";
        cfg_write('h38, 32'd3);
        send_frame(MC, 0, 1, "R6");
        send_frame(BC, 0, 1, "R6");
        send_frame(UC, 0, 0, "R6");
        cur_req = "R10";
        rx_enable = 1;
        cfg_write('h38, 32'hFFFF_FFF6);           // bits 1:0 = 2
        send_frame(MC, 0, 0, "R10");
        send_frame(BC, 0, 1, "R10");
        rx_enable = 0;

        // R8: write ordering
        cur_req = "R8";
        cfg_write('h38, 32'd1);
        cfg_write('h84 + 8*5, {15'd0, 1'b1, A5[47:32]});
        cfg_write('h80 + 8*5, A5[31:0]);
        cfg_write('h84 + 8*6, 32'h0001_0000);     // high of another entry consumes pending
        send_frame(A5, 0, 0, "R8");
        cfg_write('h80 + 8*5, A5[31:0]);
        cfg_write('h80 + 8*6, 32'h1234_5678);
        cfg_write('h84 + 8*5, {15'd0, 1'b1, A5[47:32]});
        send_frame(A5, 0, 0, "R8");
        cfg_write('h80 + 8*7, A7[31:0]);
        cfg_write('h38, 32'd1);
        cfg_write('h84 + 8*7, {15'd0, 1'b1, A7[47:32]});
        send_frame(A7, 0, 1, "R8");

        // R9: table frozen while running
        cur_req = "R9";
        rx_enable = 1;
        wr_entry(8, A8, 1);
        wr_entry(3, A3, 0);
        send_frame(A8, 0, 0, "R9");
        send_frame(A3, 0, 1, "R9");
        rx_enable = 0;
        send_frame(A8, 0, 0, "R9");

        // R11: invalid entry ignored
        cur_req = "R11";
        wr_entry(3, A3, 0);
        send_frame(A3, 0, 0, "R11");
        send_frame(A7, 0, 1, "R11");

        // R2: timing corner cases
        cur_req = "R2";
        send_frame(A7, 2, 1, "R2");               // gaps between header bytes
        partial(A3, 3);                           // restarted by next start
        send_frame(A7, 0, 1, "R2");
        send_frame(A7, 0, 0, "R2", 0);            // no start of frame: no verdict
        idle(3);

        summary();
        $finish;
    end

endmodule